// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the control side of a byte-wide parallel flash device. It watches every write bus cycle (an address with a data byte) and follows the multi-write unlock sequences that the host issues. Those sequences start a byte program, start a whole-array erase, permanently lock the low boot sector, or switch the identification readout on and off. A recognised program or erase raises a busy flag for a fixed number of clock cycles. While the flag is high, the block presents the operation kind and the captured target address and data to the array logic.

The block also holds two flags. The boot-lock flag is a stand-in for a non-volatile bit and is cleared only by reset. The identification flag selects a small readout of the manufacturer code, the device code and the lock state. Once the boot sector is locked, program commands aimed at it are dropped, and an erase is marked so that the array leaves that sector intact. The storage array and supply sensing are outside the block.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, busy is 0, op_type is 0, op_addr and op_data are 0, and boot_locked, id_mode and keep_boot are 0.
- R2: Every command opens with the unlock pair: data AA at address 5555h, then data 55 at address 2AAAh. Only the low 15 address bits are compared, so bits 16 and 15 of these writes are ignored.
- R3: A write that does not carry the expected address and byte at any step of a sequence returns the decoder to idle, and that write has no effect.
- R4: After the unlock pair, A0 at 5555h followed by any fourth write starts a program. In the cycle after that fourth write, op_type is 1 (program), and op_addr and op_data hold the address and byte of the fourth write. op_type is 0 whenever busy is 0 and nonzero whenever busy is 1.
- R5: The six-write sequence AA@5555h, 55@2AAAh, 80@5555h, AA@5555h, 55@2AAAh, 10@5555h starts an erase, with op_type 2.
- R6: busy rises in the cycle after the starting write and stays high for exactly PROG_CYCLES clock cycles for a program, or ERASE_CYCLES cycles for an erase.
- R7: Writes made while busy is 1 are ignored and do not advance any sequence.
- R8: The erase sequence with a final byte of 40 instead of 10 sets boot_locked and starts no operation. boot_locked then stays 1 until reset.
- R9: While boot_locked is 1, a program whose target lies in 00000h to 01FFFh is dropped (busy stays 0). Targets at 02000h and above are still programmed.
- R10: keep_boot is 1 for the whole of an erase started while boot_locked is 1, and 0 otherwise.
- R11: AA@5555h, 55@2AAAh, 90@5555h sets id_mode. id_mode is cleared either by the three-write sequence ending in F0@5555h, or by a lone write of F0 to any address from idle.
- R12: While id_mode is 1, id_data returns 1Fh for rd_addr 0, 17h for rd_addr 1, and {7'b0, boot_locked} for rd_addr 2. In every other case id_data is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | ADDR_W | Address for the identification readout |
| busy | output | 1 | Program or erase in progress |
| op_type | output | 2 | 0 none, 1 program, 2 erase |
| op_addr | output | ADDR_W | Target address of the latest program |
| op_data | output | 8 | Data byte of the latest program |
| keep_boot | output | 1 | The running erase must spare the boot sector |
| boot_locked | output | 1 | Boot sector lock flag |
| id_mode | output | 1 | Identification readout active |
| id_data | output | 8 | Identification readout byte |

## Verification
The hardest situations to reach are the locked-sector ones. The lock can only be set by a complete six-write sequence, and it can only be cleared by reset. A dropped program to the boot sector, and an erase that spares that sector, therefore both need the lock set earlier in the same run. The stimulus table sets the lock part-way through, then aims programs at the last protected address and at the first unprotected one. A directed erase follows under the lock, and a final reset shows the flag clearing. Writes issued during a running program check that no sequence advances while busy.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2
  } op_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_UNL1,
    SQ_UNL2,
    SQ_PGM,
    SQ_ERA1,
    SQ_ERA2,
    SQ_ERA3
  } seq_e;

  localparam int unsigned MATCH_W = 15;
  localparam logic [MATCH_W-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [MATCH_W-1:0] KEY_ADDR_B = 15'h2AAA;

  localparam logic [7:0] KEY_FIRST   = 8'hAA;
  localparam logic [7:0] KEY_SECOND  = 8'h55;
  localparam logic [7:0] CMD_PROG    = 8'hA0;
  localparam logic [7:0] CMD_EXTEND  = 8'h80;
  localparam logic [7:0] CMD_ID_ON   = 8'h90;
  localparam logic [7:0] CMD_ID_OFF  = 8'hF0;
  localparam logic [7:0] CMD_ERASE   = 8'h10;
  localparam logic [7:0] CMD_LOCK    = 8'h40;

endpackage

// File: rtl/flash_seq_decoder.sv
module flash_seq_decoder
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned BOOT_ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              accept,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              locked,
  output logic              start_prog,
  output logic              start_erase,
  output logic              set_lock,
  output logic              id_set,
  output logic              id_clr
);

  seq_e state_q;
  seq_e state_d;
  logic take;
  logic hit_a;
  logic hit_b;
  logic in_boot;

  assign take    = wr_en & accept;
  assign hit_a   = (wr_addr[MATCH_W-1:0] == KEY_ADDR_A);
  assign hit_b   = (wr_addr[MATCH_W-1:0] == KEY_ADDR_B);
  assign in_boot = (wr_addr[ADDR_W-1:BOOT_ADDR_W] == '0);

  always_comb begin
    state_d     = state_q;
    start_prog  = 1'b0;
    start_erase = 1'b0;
    set_lock    = 1'b0;
    id_set      = 1'b0;
    id_clr      = 1'b0;
    if (take) begin
      state_d = SQ_IDLE;
      unique case (state_q)
        SQ_IDLE: begin
          if (hit_a && wr_data == KEY_FIRST) state_d = SQ_UNL1;
          else if (wr_data == CMD_ID_OFF)    id_clr  = 1'b1;
        end
        SQ_UNL1: begin
          if (hit_b && wr_data == KEY_SECOND) state_d = SQ_UNL2;
        end
        SQ_UNL2: begin
          if (hit_a) begin
            case (wr_data)
              CMD_PROG:   state_d = SQ_PGM;
              CMD_EXTEND: state_d = SQ_ERA1;
              CMD_ID_ON:  id_set  = 1'b1;
              CMD_ID_OFF: id_clr  = 1'b1;
              default:    state_d = SQ_IDLE;
            endcase
          end
        end
        SQ_PGM: begin
          start_prog = !(locked && in_boot);
        end
        SQ_ERA1: begin
          if (hit_a && wr_data == KEY_FIRST) state_d = SQ_ERA2;
        end
        SQ_ERA2: begin
          if (hit_b && wr_data == KEY_SECOND) state_d = SQ_ERA3;
        end
        SQ_ERA3: begin
          if (hit_a && wr_data == CMD_ERASE) start_erase = 1'b1;
          if (hit_a && wr_data == CMD_LOCK)  set_lock    = 1'b1;
        end
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
    end else if (take) begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W       = 17,
  parameter int unsigned PROG_CYCLES  = 500,
  parameter int unsigned ERASE_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_prog,
  input  logic              start_erase,
  input  logic              locked,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [7:0]        tgt_data,
  output logic              busy,
  output logic [1:0]        op_type,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data,
  output logic              keep_boot
);

  localparam int unsigned MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  op_e               op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        data_q, data_d;
  logic              keep_q, keep_d;
  logic              run;
  logic              en;

  assign run = (cnt_q != '0);
  assign en  = start_prog | start_erase | run;

  always_comb begin
    cnt_d  = cnt_q;
    op_d   = op_q;
    addr_d = addr_q;
    data_d = data_q;
    keep_d = keep_q;
    if (start_prog) begin
      cnt_d  = CNT_W'(PROG_CYCLES);
      op_d   = OP_PROG;
      addr_d = tgt_addr;
      data_d = tgt_data;
      keep_d = 1'b0;
    end else if (start_erase) begin
      cnt_d  = CNT_W'(ERASE_CYCLES);
      op_d   = OP_ERASE;
      keep_d = locked;
    end else if (run) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        op_d   = OP_NONE;
        keep_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      op_q   <= OP_NONE;
      addr_q <= '0;
      data_q <= '0;
      keep_q <= 1'b0;
    end else if (en) begin
      cnt_q  <= cnt_d;
      op_q   <= op_d;
      addr_q <= addr_d;
      data_q <= data_d;
      keep_q <= keep_d;
    end
  end

  assign busy      = run;
  assign op_type   = op_q;
  assign op_addr   = addr_q;
  assign op_data   = data_q;
  assign keep_boot = keep_q;

endmodule

// File: rtl/flash_id_readout.sv
module flash_id_readout #(
  parameter int unsigned ADDR_W   = 17,
  parameter logic [7:0]  MFR_CODE = 8'h1F,
  parameter logic [7:0]  DEV_CODE = 8'h17
) (
  input  logic              id_mode,
  input  logic              locked,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        id_data
);

  always_comb begin
    id_data = 8'h00;
    if (id_mode) begin
      if (rd_addr == ADDR_W'(0))      id_data = MFR_CODE;
      else if (rd_addr == ADDR_W'(1)) id_data = DEV_CODE;
      else if (rd_addr == ADDR_W'(2)) id_data = {7'b0, locked};
    end
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int unsigned ADDR_W       = 17,
  parameter int unsigned BOOT_ADDR_W  = 13,
  parameter int unsigned PROG_CYCLES  = 500,
  parameter int unsigned ERASE_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              busy,
  output logic [1:0]        op_type,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data,
  output logic              keep_boot,
  output logic              boot_locked,
  output logic              id_mode,
  output logic [7:0]        id_data
);

  logic start_prog;
  logic start_erase;
  logic set_lock;
  logic id_set;
  logic id_clr;
  logic lock_q, lock_d;
  logic idm_q, idm_d;
  logic busy_w;

  flash_seq_decoder #(
    .ADDR_W      (ADDR_W),
    .BOOT_ADDR_W (BOOT_ADDR_W)
  ) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .accept      (!busy_w),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .locked      (lock_q),
    .start_prog  (start_prog),
    .start_erase (start_erase),
    .set_lock    (set_lock),
    .id_set      (id_set),
    .id_clr      (id_clr)
  );

  flash_op_timer #(
    .ADDR_W       (ADDR_W),
    .PROG_CYCLES  (PROG_CYCLES),
    .ERASE_CYCLES (ERASE_CYCLES)
  ) tmr_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_prog  (start_prog),
    .start_erase (start_erase),
    .locked      (lock_q),
    .tgt_addr    (wr_addr),
    .tgt_data    (wr_data),
    .busy        (busy_w),
    .op_type     (op_type),
    .op_addr     (op_addr),
    .op_data     (op_data),
    .keep_boot   (keep_boot)
  );

  flash_id_readout #(
    .ADDR_W (ADDR_W)
  ) idr_i (
    .id_mode (idm_q),
    .locked  (lock_q),
    .rd_addr (rd_addr),
    .id_data (id_data)
  );

  always_comb begin
    lock_d = lock_q | set_lock;
    idm_d  = idm_q;
    if (id_set)      idm_d = 1'b1;
    else if (id_clr) idm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      idm_q  <= 1'b0;
    end else if (set_lock | id_set | id_clr) begin
      lock_q <= lock_d;
      idm_q  <= idm_d;
    end
  end

  assign busy        = busy_w;
  assign boot_locked = lock_q;
  assign id_mode     = idm_q;

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int unsigned ADDR_W       = 17,
  parameter int unsigned BOOT_ADDR_W  = 13,
  parameter int unsigned PROG_CYCLES  = 500,
  parameter int unsigned ERASE_CYCLES = 5000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              busy,
  input logic [1:0]        op_type,
  input logic [ADDR_W-1:0] op_addr,
  input logic              keep_boot,
  input logic              boot_locked,
  input logic              id_mode
);

  logic [31:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    len_q <= '0;
    else if (busy) len_q <= len_q + 32'd1;
    else           len_q <= '0;
  end

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (len_q == PROG_CYCLES || len_q == ERASE_CYCLES));

  // R4
  busy_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (op_type == 2'd1 || op_type == 2'd2));

  // R4
  idle_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (op_type == 2'd0));

  // R5
  start_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en));

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> ($stable(boot_locked) && $stable(id_mode)));

  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(boot_locked));

  // R9
  boot_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_type == 2'd1 && boot_locked) |-> (op_addr[ADDR_W-1:BOOT_ADDR_W] != '0));

  // R10
  keep_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_type == 2'd2) |-> (keep_boot == boot_locked));

  // R10
  keep_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_type != 2'd2) |-> !keep_boot);

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(
  .ADDR_W       (ADDR_W),
  .BOOT_ADDR_W  (BOOT_ADDR_W),
  .PROG_CYCLES  (PROG_CYCLES),
  .ERASE_CYCLES (ERASE_CYCLES)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .busy        (busy),
  .op_type     (op_type),
  .op_addr     (op_addr),
  .keep_boot   (keep_boot),
  .boot_locked (boot_locked),
  .id_mode     (id_mode)
);

// File: tb/flash_cmd_ctrl_tb_top.sv
module flash_cmd_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 17;
  localparam int PROG_N     = 8;
  localparam int ERASE_N    = 20;
  localparam int NVEC       = 38;

  // {addr, data, busy, op, id, lock, req}
  localparam logic [33:0] VEC [NVEC] = '{
    {17'h05555, 8'hAA, 1'b0, 2'd0, 1'b0, 1'b0, 4'd2},
    {17'h02AAA, 8'h55, 1'b0, 2'd0, 1'b0, 1'b0, 4'd2},
    {17'h05555, 8'h90, 1'b0, 2'd0, 1'b1, 1'b0, 4'd11},
    {17'h01234, 8'hF0, 1'b0, 2'd0, 1'b0, 1'b0, 4'd11},
    {17'h05555, 8'hAA, 1'b0, 2'd0, 1'b0, 1'b0, 4'd4},
    {17'h02AAA, 8'h55, 1'b0, 2'd0, 1'b0, 1'b0, 4'd4},
    {17'h05555, 8'hA0, 1'b0, 2'd0, 1'b0, 1'b0, 4'd4},
    {17'h00100, 8'h3C, 1'b1, 2'd1, 1'b0, 1'b0, 4'd4},
    {17'h05555, 8'hAA, 1'b0, 2'd0, 1'b0, 1'b0, 4'd5},
    {17'h02AAA, 8'h55, 1'b0, 2'd0, 1'b0, 1'b0, 4'd5},
    {17'h05555, 8'h80, 1'b0, 2'd0, 1'b0, 1'b0, 4'd5},
    {17'h05555, 8'hAA, 1'b0, 2'd0, 1'b0, 1'b0, 4'd5},
    {17'h02AAA, 8'h55, 1'b0, 2'd0, 1'b0, 1'b0, 4'd5},
    {17'h05555, 8'h10, 1'b1, 2'd2, 1'b0, 1'b0, 4'd5},
    {17'h05555, 8'hAA, 1'b0, 2'd0, 1'b0, 1'b0, 4'd3},
    {17'h02AAA, 8'h56, 1'b0, 2'd0, 1'b0, 1'b0, 4'd3},
    {17'h05555, 8'h90, 1'b0, 2'd0, 1'b0, 1'b0, 4'd3},
    {17'h0D555, 8'hAA, 1'b0, 2'd0, 1'b0, 1'b0, 4'd2},
    {17'h12AAA, 8'h55, 1'b0, 2'd0, 1'b0, 1'b0, 4'd2},
    {17'h05555, 8'h90, 1'b0, 2'd0, 1'b1, 1'b0, 4'd2},
    {17'h05555, 8'hAA, 1'b0, 2'd0, 1'b1, 1'b0, 4'd11},
    {17'h02AAA, 8'h55, 1'b0, 2'd0, 1'b1, 1'b0, 4'd11},
    {17'h05555, 8'hF0, 1'b0, 2'd0, 1'b0, 1'b0, 4'd11},
    {17'h05555, 8'hAA, 1'b0, 2'd0, 1'b0, 1'b0, 4'd8},
    {17'h02AAA, 8'h55, 1'b0, 2'd0, 1'b0, 1'b0, 4'd8},
    {17'h05555, 8'h80, 1'b0, 2'd0, 1'b0, 1'b0, 4'd8},
    {17'h05555, 8'hAA, 1'b0, 2'd0, 1'b0, 1'b0, 4'd8},
    {17'h02AAA, 8'h55, 1'b0, 2'd0, 1'b0, 1'b0, 4'd8},
    {17'h05555, 8'h40, 1'b0, 2'd0, 1'b0, 1'b1, 4'd8},
    {17'h05555, 8'hAA, 1'b0, 2'd0, 1'b0, 1'b1, 4'd9},
    {17'h02AAA, 8'h55, 1'b0, 2'd0, 1'b0, 1'b1, 4'd9},
    {17'h05555, 8'hA0, 1'b0, 2'd0, 1'b0, 1'b1, 4'd9},
    {17'h01FFF, 8'h77, 1'b0, 2'd0, 1'b0, 1'b1, 4'd9},
    {17'h05555, 8'hAA, 1'b0, 2'd0, 1'b0, 1'b1, 4'd9},
    {17'h02AAA, 8'h55, 1'b0, 2'd0, 1'b0, 1'b1, 4'd9},
    {17'h05555, 8'hA0, 1'b0, 2'd0, 1'b0, 1'b1, 4'd9},
    {17'h02000, 8'h77, 1'b1, 2'd1, 1'b0, 1'b1, 4'd9},
    {17'h00000, 8'hF0, 1'b0, 2'd0, 1'b0, 1'b1, 4'd8}
  };

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic [AW-1:0] rd_addr;
  logic          busy;
  logic [1:0]    op_type;
  logic [AW-1:0] op_addr;
  logic [7:0]    op_data;
  logic          keep_boot;
  logic          boot_locked;
  logic          id_mode;
  logic [7:0]    id_data;

  int checks;
  int errors;
  bit done;

  flash_cmd_ctrl #(
    .ADDR_W       (AW),
    .BOOT_ADDR_W  (13),
    .PROG_CYCLES  (PROG_N),
    .ERASE_CYCLES (ERASE_N)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_addr     (rd_addr),
    .busy        (busy),
    .op_type     (op_type),
    .op_addr     (op_addr),
    .op_data     (op_data),
    .keep_boot   (keep_boot),
    .boot_locked (boot_locked),
    .id_mode     (id_mode),
    .id_data     (id_data)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  function automatic string tag_of(input logic [3:0] n);
    case (n)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd8:    return "R8";
      4'd9:    return "R9";
      4'd11:   return "R11";
      default: return "R?";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic cmd3(input logic [7:0] d);
    wr(17'h05555, 8'hAA);
    wr(17'h02AAA, 8'h55);
    wr(17'h05555, d);
  endtask

  task automatic erase6();
    cmd3(8'h80);
    wr(17'h05555, 8'hAA);
    wr(17'h02AAA, 8'h55);
    wr(17'h05555, 8'h10);
  endtask

  // Count the negedges on which busy is high, starting now.
  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic drain();
    int n;
    busy_len(n);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      finish_run();
    end
  end

  initial begin
    int n;
    checks  = 0;
    errors  = 0;
    done    = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    rd_addr = '0;
    do_reset();

    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 op_type", op_type, 0);
    chk("R1 op_addr", op_addr, 0);
    chk("R1 op_data", op_data, 0);
    chk("R1 flags", {keep_boot, boot_locked, id_mode}, 0);
    chk("R12 id_data outside id mode", id_data, 8'h00);

    // R12 identification readout, unlocked
    cmd3(8'h90);
    chk("R11 id entry", id_mode, 1);
    rd_addr = 17'd0; #1 chk("R12 mfr code", id_data, 8'h1F);
    rd_addr = 17'd1; #1 chk("R12 dev code", id_data, 8'h17);
    rd_addr = 17'd2; #1 chk("R12 lock bit clear", id_data, 8'h00);
    rd_addr = 17'd3; #1 chk("R12 other address", id_data, 8'h00);
    wr(17'h1FFFF, 8'hF0);
    chk("R11 single F0 exit", id_mode, 0);
    rd_addr = 17'd0; #1 chk("R12 readout off", id_data, 8'h00);

    // R4 / R6 program capture and duration
    cmd3(8'hA0);
    wr(17'h1ABCD, 8'h5A);
    chk("R4 op_type program", op_type, 1);
    chk("R4 op_addr", op_addr, 17'h1ABCD);
    chk("R4 op_data", op_data, 8'h5A);
    busy_len(n);
    chk("R6 program length", n, PROG_N);
    chk("R4 op_type after program", op_type, 0);

    // R7 writes during busy are dropped
    cmd3(8'hA0);
    wr(17'h04000, 8'h11);
    chk("R7 busy started", busy, 1);
    wr(17'h05555, 8'hAA);
    wr(17'h02AAA, 8'h55);
    wr(17'h05555, 8'h90);
    chk("R7 id unchanged during busy", id_mode, 0);
    drain();
    wr(17'h05555, 8'h90);
    chk("R7 sequence not advanced", id_mode, 0);
    chk("R7 no extra operation", busy, 0);

    // R5 / R6 / R10 erase unlocked
    erase6();
    chk("R5 op_type erase", op_type, 2);
    chk("R10 keep_boot unlocked", keep_boot, 0);
    busy_len(n);
    chk("R6 erase length", n, ERASE_N);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][33:17], VEC[i][16:9]);
      chk(tag_of(VEC[i][3:0]), {busy, op_type, id_mode, boot_locked},
          {27'd0, VEC[i][8], VEC[i][7:6], VEC[i][5], VEC[i][4]});
      drain();
    end

    // R10 erase while locked
    erase6();
    chk("R10 op_type erase locked", op_type, 2);
    chk("R10 keep_boot locked", keep_boot, 1);
    repeat (ERASE_N - 2) @(negedge clk);
    chk("R10 keep_boot held", keep_boot, 1);
    drain();
    chk("R10 keep_boot released", keep_boot, 0);

    // R12 lock bit readout
    cmd3(8'h90);
    rd_addr = 17'd2; #1 chk("R12 lock bit set", id_data, 8'h01);
    wr(17'h00000, 8'hF0);
    chk("R11 exit", id_mode, 0);

    // R8 lock survives until reset
    chk("R8 lock before reset", boot_locked, 1);
    do_reset();
    chk("R8 lock cleared by reset", boot_locked, 0);

    finish_run();
  end

endmodule